// File: doc/BRIEF.md
# I2C Master Clock Phase Timer

This block produces the SCL waveform of an I2C master. One down-counter sets the length of both clock phases. In the low phase the block pulls SCL low for a counted time. It then lets the line go and waits until the synchronized line reads high before it starts timing the high phase. A slave that stretches the clock therefore makes the period longer, and the guaranteed high time stays the same.

An outer sequencer supplies a 7-bit divider and a level request that asks for another low phase. It receives a one-cycle strobe at the end of every high phase. When the request is low at that strobe, the block parks with SCL released until the request returns. Clearing the enable releases the line at once and resets the timing.

Top module: `scl_timer`

## Requirements
- R1: After reset, and with `en_i` low, `scl_drive_low_o` and `phase_done_o` are both 0.
- R2: A low phase begins with a reload of D, the value of `div_i[6:0]` at that cycle. `scl_drive_low_o` stays 1 for max(2*D+1, 3) cycles, because the counter steps once every second clock and the block also waits until the synchronizer reports the line low.
- R3: After release, while the SCL line stays low, the counter is frozen. `phase_done_o` stays 0 and `scl_drive_low_o` stays 0 for the whole time a slave holds the line.
- R4: From the first cycle in which the SCL line is high, up to and including the `phase_done_o` cycle, exactly 2*D+4 cycles pass, and never fewer than 2*D. This holds for any stretch length.
- R5: `phase_done_o` is high for exactly one cycle, and that cycle is the last cycle of the high phase.
- R6: If `low_req_i` is 1 in the `phase_done_o` cycle, `scl_drive_low_o` is 1 in the next cycle. If it is 0, SCL stays released and no further strobe occurs until `low_req_i` is seen high. The low phase then starts one cycle after that.
- R7: Taking `en_i` low makes `scl_drive_low_o` 0 and keeps `phase_done_o` at 0 from the next cycle on. `low_req_i` and SCL activity are ignored while disabled. After `en_i` returns, SCL stays released until `low_req_i` is seen high.
- R8: The counter stops at zero and does not wrap. D = 0 gives a 3-cycle low drive and a 4-cycle high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| div_i | input | 7 | Phase length setting D |
| low_req_i | input | 1 | Sequencer request for another low phase |
| scl_i | input | 1 | Raw SCL line level |
| scl_drive_low_o | output | 1 | Open-drain pull-down control for SCL |
| phase_done_o | output | 1 | One-cycle strobe at the end of a high phase |

## Verification
The hardest situation to reach is a released line that is still held low. During that time the counter must stay frozen, and timing must start only from the synchronized rising edge. The bench contains a slave model that grabs the line on every release and holds it for a programmable number of cycles, from zero up to fifty. For each setting it measures the stretch, the high phase and the strobe position directly on the line. Because the expected high phase is the same for every stretch length, any counting during the hold shows up as a short high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_PARK,
    ST_LOW,
    ST_WAIT,
    ST_HIGH
  } scl_state_e;
endpackage

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  // Idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '1;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/scl_brg.sv
module scl_brg #(
  parameter int CW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic          run_i,
  input  logic [CW-1:0] reload_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;
  logic          ph_q;
  logic          tick;

  assign tick   = run_i & ph_q;
  assign zero_o = (cnt_q == '0);

  // Step enable every second clock, phase restarted on reload
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               ph_q <= 1'b0;
    else if (clr_i || load_i)  ph_q <= 1'b0;
    else if (run_i)            ph_q <= ~ph_q;
    else                       ph_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (load_i)            cnt_q <= reload_i;
    else if (tick && !zero_o)   cnt_q <= cnt_q - CW'(1);
  end

  p_hold_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i && !clr_i) |=> zero_o);

  p_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !load_i && !clr_i) |=> $stable(cnt_q));

  p_single_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !clr_i) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) - CW'(1)));
endmodule

// File: rtl/scl_timer.sv
module scl_timer
  import scl_gen_pkg::*;
#(
  parameter int DIV_W       = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             low_req_i,
  input  logic             scl_i,
  output logic             scl_drive_low_o,
  output logic             phase_done_o
);
  scl_state_e state_q, state_d;
  logic       scl_s;
  logic       cnt_zero;
  logic       load;
  logic       clr;
  logic       run;

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_s)
  );

  scl_brg #(.CW(DIV_W)) u_brg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .load_i  (load),
    .run_i   (run),
    .reload_i(div_i),
    .zero_o  (cnt_zero)
  );

  assign clr = ~en_i;
  assign run = en_i & ((state_q == ST_LOW) | (state_q == ST_HIGH));

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    if (!en_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  state_d = ST_PARK;
        ST_PARK: if (low_req_i) begin
                   state_d = ST_LOW;
                   load    = 1'b1;
                 end
        // Release only once the pulled-low line is visible
        ST_LOW:  if (cnt_zero && !scl_s) state_d = ST_WAIT;
        // Frozen until the line is really high
        ST_WAIT: if (scl_s) begin
                   state_d = ST_HIGH;
                   load    = 1'b1;
                 end
        ST_HIGH: if (cnt_zero) begin
                   if (low_req_i) begin
                     state_d = ST_LOW;
                     load    = 1'b1;
                   end else begin
                     state_d = ST_PARK;
                   end
                 end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign scl_drive_low_o = (state_q == ST_LOW);
  assign phase_done_o    = en_i & (state_q == ST_HIGH) & cnt_zero;

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_done_o |=> !phase_done_o);

  p_off_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!scl_drive_low_o && !phase_done_o));

  p_wait_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !scl_s && en_i) |=> (!phase_done_o && !scl_drive_low_o));

  p_done_then_drive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_done_o && low_req_i) |=> scl_drive_low_o);

  p_park_no_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PARK) |-> !phase_done_o);
endmodule

// File: tb/scl_timer_bench.sv
module scl_timer_bench;
  localparam int NV = 8;
  localparam int VDIV [NV] = '{3, 5, 1, 10, 0, 127, 20, 7};
  localparam int VSTR [NV] = '{0, 7, 20, 3, 5, 2, 50, 1};
  localparam int VLOW [NV] = '{7, 11, 3, 21, 3, 255, 41, 15};
  localparam int VHIGH[NV] = '{10, 14, 6, 24, 4, 258, 44, 18};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [6:0] div = '0;
  logic       low_req = 1'b0;
  logic       scl_line;
  logic       drive_low;
  logic       done;
  int         stretch = 0;
  int         hold_left = 0;
  int         tests = 0;
  int         fails = 0;
  int         cyc = 0;
  bit         ended = 1'b0;

  always #2.5 clk = ~clk;

  // Slave grabs the line on each release and holds it for `stretch` cycles
  always_ff @(posedge clk) begin
    if (drive_low)          hold_left <= stretch;
    else if (hold_left > 0) hold_left <= hold_left - 1;
  end

  assign scl_line = !(drive_low || hold_left != 0);

  scl_timer u_scl_timer (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .en_i           (en),
    .div_i          (div),
    .low_req_i      (low_req),
    .scl_i          (scl_line),
    .scl_drive_low_o(drive_low),
    .phase_done_o   (done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      finish_run();
    end
  end

  // One parked-to-parked clock period; req pulsed for one cycle
  task automatic run_period(input int d, input int s, input int exp_low, input int exp_high);
    int n_low = 0;
    int n_str = 0;
    int n_high = 0;
    int n_done = 0;
    bit got = 1'b0;
    div = 7'(d);
    stretch = s;
    @(negedge clk) low_req = 1'b1;
    @(negedge clk) low_req = 1'b0;
    while (drive_low && n_low < 1000) begin
      if (done) n_done++;
      n_low++;
      @(negedge clk);
    end
    chk(n_low == exp_low, "R2 low drive length", n_low, exp_low);
    while (!scl_line && !drive_low && n_str < 1000) begin
      if (done) n_done++;
      n_str++;
      @(negedge clk);
    end
    chk(n_str == s, "R3 stretch seen on line", n_str, s);
    chk(n_done == 0, "R3 no strobe while held", n_done, 0);
    while (!got && n_high < 1000) begin
      n_high++;
      if (!scl_line || drive_low) begin
        chk(0, "R4 line high through phase", 0, 1);
        got = 1'b1;
      end else if (done) begin
        got = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
    chk(n_high == exp_high, "R4 high length", n_high, exp_high);
    chk(n_high >= 2 * d, "R4 high at least 2*D", n_high, 2 * d);
    @(negedge clk);
    chk(!done, "R5 strobe one cycle", int'(done), 0);
    chk(!drive_low, "R6 parked after strobe", int'(drive_low), 0);
    repeat (5) begin
      @(negedge clk);
      chk(!drive_low && !done, "R6 stays parked", int'(drive_low | done), 0);
    end
  endtask

  initial begin
    int n;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(!drive_low && !done, "R1 in reset", int'(drive_low | done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!drive_low && !done, "R1 disabled after reset", int'(drive_low | done), 0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    chk(!drive_low, "R7 enabled but parked", int'(drive_low), 0);

    for (int i = 0; i < NV; i++)
      run_period(VDIV[i], VSTR[i], VLOW[i], VHIGH[i]);

    // R6 continuous: request held, next low begins right after strobe
    div = 7'd4;
    stretch = 2;
    @(negedge clk) low_req = 1'b1;
    n = 0;
    while (!done && n < 1000) begin n++; @(negedge clk); end
    @(negedge clk);
    chk(drive_low, "R6 drive right after strobe", int'(drive_low), 1);
    n = 0;
    while (drive_low && n < 1000) begin n++; @(negedge clk); end
    chk(n == 9, "R2 second low phase length", n, 9);
    n = 0;
    while (!done && n < 1000) begin n++; @(negedge clk); end
    @(negedge clk) low_req = 1'b0;
    n = 0;
    while (!done && n < 1000) begin n++; @(negedge clk); end
    @(negedge clk);
    chk(!drive_low, "R6 parks when request drops", int'(drive_low), 0);

    // R7 disable in the middle of a low phase
    div = 7'd20;
    stretch = 0;
    @(negedge clk) low_req = 1'b1;
    repeat (5) @(negedge clk);
    chk(drive_low, "R2 low phase in progress", int'(drive_low), 1);
    en = 1'b0;
    @(negedge clk);
    chk(!drive_low && !done, "R7 released next cycle", int'(drive_low | done), 0);
    n = 0;
    repeat (30) begin
      @(negedge clk);
      if (drive_low || done) n++;
    end
    chk(n == 0, "R7 request ignored while off", n, 0);
    low_req = 1'b0;
    en = 1'b1;
    repeat (6) @(negedge clk);
    chk(!drive_low && !done, "R7 parked after enable", int'(drive_low | done), 0);
    run_period(2, 4, 5, 8);

    finish_run();
  end
endmodule